// File: doc/BRIEF.md
# Zero-Overhead Loop and Repeat PC Sequencer

This block works out the program counter for the next instruction of a DSP that runs loops with no branch instruction and can repeat a single instruction a set number of times. Every cycle it looks at the current PC, the size of the current instruction and a flag that says whether the instruction moves the PC by itself. From these and from its own state it forms the next PC. That state is a repeat counter and a nest of loop frames. Each frame holds a start address, an end address and an iteration count, and the three values sit in three lockstep stacks of four entries each.

The stacks and the counter change only on a step strobe, which marks one retiring instruction. A loop-push command and a repeat-load command can come in any cycle, including a stepping one. The next PC is combinational, so the fetch stage can use it in the same cycle. The interface has only control and status pins. No stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. Commands are taken in the cycle they are asserted.

Top module: `pc_loop_sequencer`

## Requirements
- R1: Reset leaves the stacks empty (`stk_empty`=1, `stk_full`=0), clears the overflow flag and sets the repeat counter to 0.
- R2: When `flow_ctl` is high, `next_pc` equals `cur_pc`. A step in that cycle leaves the repeat counter and the loop stacks unchanged.
- R3: On a non-flow step with a repeat count above 1, the counter drops by one and `next_pc` equals `cur_pc`, so the same instruction runs again.
- R4: On a non-flow step with a repeat count of exactly 1, the counter becomes 0 and the loop and advance rules (R5–R7) decide `next_pc` in that same cycle.
- R5: When the repeat rule does not hold the PC, the stacks are non-empty, `cur_pc` equals the top end address and the top count is above 1, `next_pc` is the top start address and a step lowers the top count by one in place.
- R6: Under the same match with a top count of 1, `next_pc` is `cur_pc`+1 whatever the instruction size, and a step pops all three stacks together.
- R7: With no hold and no loop match, `next_pc` is `cur_pc` plus `instr_bytes` shifted right by one, so the size is counted in 16-bit words and an odd byte count rounds down. The sum wraps at 16 bits.
- R8: A loop-push writes start, end and count onto their three stacks in one cycle. `stk_full` rises at 4 frames and `stk_empty` is high only with 0 frames.
- R9: A push that meets a full nest leaves every stack unchanged and sets `stk_err`. The flag stays set until reset.
- R10: A repeat-load sets the counter, and the new count first acts on the following step. When a load and a step fall in the same cycle, the load wins and there is no decrement.
- R11: When a push and a popping or decrementing step fall in the same cycle, the step acts first. The new frame lands on top of the stack that results, and it counts as an overflow only if that stack is still full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction retires this cycle |
| cur_pc | input | 16 | PC of the current instruction (word address) |
| instr_bytes | input | 3 | Size of the current instruction in bytes |
| flow_ctl | input | 1 | Current instruction sets the PC itself |
| loop_push | input | 1 | Push a loop frame |
| push_start | input | 16 | Loop start address to push |
| push_end | input | 16 | Loop end address to push |
| push_count | input | 16 | Loop iteration count to push |
| rep_load | input | 1 | Load the repeat counter |
| rep_count | input | 16 | Value for the repeat counter |
| next_pc | output | 16 | PC to fetch next |
| stk_empty | output | 1 | No loop frame held |
| stk_full | output | 1 | All four frames in use |
| stk_err | output | 1 | Sticky push-overflow flag |
| rep_remaining | output | 16 | Current repeat counter |

## Verification
Two pairs of functions can meet in one cycle: a stepping pop or decrement with a loop-push, and a stepping decrement with a repeat-load. The bench makes them meet by asserting the command in the cycle where a step exits a loop frame or starts a repeat. It then judges the outcome only through the ports. `stk_empty` and `stk_full` give the resulting depth, and later steps at the pushed end address show which frame sits on top and whether the old count was kept. The counter value seen after the load shows which of the two acted.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

  // Outcome chosen for the current instruction.
  typedef enum logic [2:0] {
    ACT_FLOW = 3'd0,  // instruction moves the PC itself
    ACT_HOLD = 3'd1,  // repeat in progress, same instruction again
    ACT_BACK = 3'd2,  // loop end reached, iterations left
    ACT_EXIT = 3'd3,  // loop end reached, last iteration
    ACT_ADV  = 3'd4   // plain sequential advance
  } seq_act_e;

  // Lane numbering of the frame stacks.
  localparam int LANE_START = 0;
  localparam int LANE_END   = 1;
  localparam int ADDR_LANES = 2;

endpackage

// File: rtl/lpseq_lifo.sv
// One lane of the loop-frame nest: a register file indexed by an
// externally managed depth. A push port writes the slot above the top;
// an optional modify port rewrites the top slot in place.
module lpseq_lifo #(
  parameter int DEPTH    = 4,
  parameter int W        = 16,
  parameter bit MOD_PORT = 1'b0,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [IDX_W-1:0] push_idx,
  input  logic [W-1:0]     push_data,
  input  logic             mod_en,
  input  logic [IDX_W-1:0] mod_idx,
  input  logic [W-1:0]     mod_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);

  logic [W-1:0] slots [DEPTH];
  logic         mod_ok;

  assign mod_ok  = MOD_PORT && mod_en;
  assign rd_data = slots[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      // Modify and push never target the same slot (top vs. above top).
      if (mod_ok)  slots[mod_idx]  <= mod_data;
      if (push_en) slots[push_idx] <= push_data;
    end
  end

endmodule

// File: rtl/lpseq_repeat.sv
// Single-instruction repeat counter.
module lpseq_repeat #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             last
);

  assign busy = (count != '0);
  assign last = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (load)            count <= load_val;
    else if (advance && busy) count <= count - CNT_W'(1);
  end

endmodule

// File: rtl/lpseq_depth.sv
// Shared depth pointer of the three lanes plus the sticky overflow flag.
// A pop from the current step is applied before a push in the same cycle.
module lpseq_depth #(
  parameter int DEPTH  = 4,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push_req,
  output logic             push_go,
  output logic [IDX_W-1:0] push_idx,
  output logic [IDX_W-1:0] top_idx,
  output logic             empty,
  output logic             full,
  output logic             err
);

  logic [DW-1:0] depth_q;
  logic [DW-1:0] after_pop;
  logic [DW-1:0] top_pos;
  logic          room;

  assign after_pop = depth_q - DW'(pop);
  assign room      = (after_pop != DW'(DEPTH));
  assign push_go   = push_req && room;
  assign push_idx  = after_pop[IDX_W-1:0];
  assign top_pos   = depth_q - DW'(1);
  assign top_idx   = top_pos[IDX_W-1:0];
  assign empty     = (depth_q == '0);
  assign full      = (depth_q == DW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
      err     <= 1'b0;
    end else begin
      depth_q <= after_pop + DW'(push_go);
      if (push_req && !room) err <= 1'b1;
    end
  end

endmodule

// File: rtl/lpseq_ctrl.sv
// Combinational decision of the next PC and of the action on the state.
module lpseq_ctrl
  import lpseq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              flow_ctl,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [SIZE_W-1:0] instr_bytes,
  input  logic              rep_busy,
  input  logic              rep_last,
  input  logic              nest_live,
  input  logic [PC_W-1:0]   top_start,
  input  logic [PC_W-1:0]   top_end,
  input  logic [CNT_W-1:0]  top_cnt,
  output seq_act_e          act,
  output logic [PC_W-1:0]   next_pc,
  output logic [CNT_W-1:0]  cnt_dec
);

  logic [PC_W-1:0] words;

  assign words   = PC_W'(instr_bytes >> 1);
  assign cnt_dec = top_cnt - CNT_W'(1);

  always_comb begin
    if (flow_ctl) begin
      act     = ACT_FLOW;
      next_pc = cur_pc;
    end else if (rep_busy && !rep_last) begin
      act     = ACT_HOLD;
      next_pc = cur_pc;
    end else if (nest_live && (cur_pc == top_end)) begin
      if (cnt_dec != '0) begin
        act     = ACT_BACK;
        next_pc = top_start;
      end else begin
        act     = ACT_EXIT;
        next_pc = cur_pc + PC_W'(1);
      end
    end else begin
      act     = ACT_ADV;
      next_pc = cur_pc + words;
    end
  end

endmodule

// File: rtl/pc_loop_sequencer.sv
module pc_loop_sequencer
  import lpseq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [SIZE_W-1:0] instr_bytes,
  input  logic              flow_ctl,
  input  logic              loop_push,
  input  logic [PC_W-1:0]   push_start,
  input  logic [PC_W-1:0]   push_end,
  input  logic [CNT_W-1:0]  push_count,
  input  logic              rep_load,
  input  logic [CNT_W-1:0]  rep_count,
  output logic [PC_W-1:0]   next_pc,
  output logic              stk_empty,
  output logic              stk_full,
  output logic              stk_err,
  output logic [CNT_W-1:0]  rep_remaining
);

  seq_act_e         act;
  logic             rep_busy, rep_last;
  logic             push_go;
  logic [IDX_W-1:0] push_idx, top_idx;
  logic [PC_W-1:0]  top_addr [ADDR_LANES];
  logic [PC_W-1:0]  lane_in  [ADDR_LANES];
  logic [CNT_W-1:0] top_cnt, cnt_dec;
  logic             do_pop, do_mod;

  assign do_pop = step && (act == ACT_EXIT);
  assign do_mod = step && (act == ACT_BACK);

  assign lane_in[LANE_START] = push_start;
  assign lane_in[LANE_END]   = push_end;

  lpseq_repeat #(.CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (step && !flow_ctl),
    .load     (rep_load),
    .load_val (rep_count),
    .count    (rep_remaining),
    .busy     (rep_busy),
    .last     (rep_last)
  );

  lpseq_depth #(.DEPTH(DEPTH)) u_depth (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (do_pop),
    .push_req (loop_push),
    .push_go  (push_go),
    .push_idx (push_idx),
    .top_idx  (top_idx),
    .empty    (stk_empty),
    .full     (stk_full),
    .err      (stk_err)
  );

  // Address lanes: push only. Count lane: push plus in-place decrement.
  for (genvar g = 0; g < ADDR_LANES; g++) begin : g_addr_lane
    lpseq_lifo #(.DEPTH(DEPTH), .W(PC_W), .MOD_PORT(1'b0)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_go),
      .push_idx  (push_idx),
      .push_data (lane_in[g]),
      .mod_en    (1'b0),
      .mod_idx   ('0),
      .mod_data  ('0),
      .rd_idx    (top_idx),
      .rd_data   (top_addr[g])
    );
  end

  lpseq_lifo #(.DEPTH(DEPTH), .W(CNT_W), .MOD_PORT(1'b1)) u_cnt_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_go),
    .push_idx  (push_idx),
    .push_data (push_count),
    .mod_en    (do_mod),
    .mod_idx   (top_idx),
    .mod_data  (cnt_dec),
    .rd_idx    (top_idx),
    .rd_data   (top_cnt)
  );

  lpseq_ctrl #(.PC_W(PC_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_ctrl (
    .flow_ctl    (flow_ctl),
    .cur_pc      (cur_pc),
    .instr_bytes (instr_bytes),
    .rep_busy    (rep_busy),
    .rep_last    (rep_last),
    .nest_live   (!stk_empty),
    .top_start   (top_addr[LANE_START]),
    .top_end     (top_addr[LANE_END]),
    .top_cnt     (top_cnt),
    .act         (act),
    .next_pc     (next_pc),
    .cnt_dec     (cnt_dec)
  );

endmodule

// File: rtl/lpseq_checker.sv
module lpseq_checker #(
  parameter int PC_W   = 16,
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic [PC_W-1:0]   cur_pc,
  input logic [SIZE_W-1:0] instr_bytes,
  input logic              flow_ctl,
  input logic              loop_push,
  input logic              rep_load,
  input logic [CNT_W-1:0]  rep_count,
  input logic [PC_W-1:0]   next_pc,
  input logic              stk_empty,
  input logic              stk_full,
  input logic              stk_err,
  input logic [CNT_W-1:0]  rep_remaining
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (stk_empty && !stk_full && !stk_err && rep_remaining == '0));

  a_r2_flow_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (step && flow_ctl && !rep_load && !loop_push)
      |=> ($stable(rep_remaining) && $stable(stk_empty) && $stable(stk_full)));

  a_r3_repeat_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flow_ctl && rep_remaining > CNT_W'(1)) |-> (next_pc == cur_pc));

  a_r3_repeat_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flow_ctl && !rep_load && rep_remaining != '0)
      |=> (rep_remaining == $past(rep_remaining) - CNT_W'(1)));

  a_r7_plain_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_ctl && stk_empty && rep_remaining == '0)
      |-> (next_pc == cur_pc + PC_W'(instr_bytes >> 1)));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_empty && stk_full));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  a_r9_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_push && stk_full && !step) |=> (stk_err && stk_full));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rep_load |=> (rep_remaining == $past(rep_count)));

endmodule

bind pc_loop_sequencer lpseq_checker #(
  .PC_W(PC_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
) u_lpseq_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .step          (step),
  .cur_pc        (cur_pc),
  .instr_bytes   (instr_bytes),
  .flow_ctl      (flow_ctl),
  .loop_push     (loop_push),
  .rep_load      (rep_load),
  .rep_count     (rep_count),
  .next_pc       (next_pc),
  .stk_empty     (stk_empty),
  .stk_full      (stk_full),
  .stk_err       (stk_err),
  .rep_remaining (rep_remaining)
);

// File: tb/test_pc_loop_sequencer.sv
module test_pc_loop_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [2:0]  instr_bytes = 3'd2;
  logic        flow_ctl = 1'b0;
  logic        loop_push = 1'b0;
  logic [15:0] push_start = '0, push_end = '0, push_count = '0;
  logic        rep_load = 1'b0;
  logic [15:0] rep_count = '0;
  logic [15:0] next_pc;
  logic        stk_empty, stk_full, stk_err;
  logic [15:0] rep_remaining;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pc_loop_sequencer i_pc_loop_sequencer (
    .clk(clk), .rst_n(rst_n), .step(step), .cur_pc(cur_pc),
    .instr_bytes(instr_bytes), .flow_ctl(flow_ctl), .loop_push(loop_push),
    .push_start(push_start), .push_end(push_end), .push_count(push_count),
    .rep_load(rep_load), .rep_count(rep_count), .next_pc(next_pc),
    .stk_empty(stk_empty), .stk_full(stk_full), .stk_err(stk_err),
    .rep_remaining(rep_remaining)
  );

  // Stimulus vectors with empty nest and idle repeat: {pc, bytes, flow, expected}
  typedef struct packed {
    logic [15:0] pc;
    logic [2:0]  bytes;
    logic        flow;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 3'd2, 1'b0, 16'h0001},
    '{16'h0010, 3'd4, 1'b0, 16'h0012},
    '{16'h00FF, 3'd6, 1'b0, 16'h0102},
    '{16'h1234, 3'd3, 1'b0, 16'h1235},
    '{16'hFFFF, 3'd2, 1'b0, 16'h0000},
    '{16'h0005, 3'd1, 1'b0, 16'h0005},
    '{16'h0400, 3'd4, 1'b1, 16'h0400}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Apply the current inputs across one rising edge, clear strobes after it.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    step = 1'b0; flow_ctl = 1'b0; loop_push = 1'b0; rep_load = 1'b0;
    #1;
  endtask

  task automatic run(input logic [15:0] pc, input logic [2:0] nb, input logic fl);
    cur_pc = pc; instr_bytes = nb; flow_ctl = fl; step = 1'b1;
    #1;
  endtask

  task automatic push(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c);
    loop_push = 1'b1; push_start = s; push_end = e; push_count = c;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", stk_empty, 1);
    chk("R1 full", stk_full, 0);
    chk("R1 err", stk_err, 0);
    chk("R1 repeat", rep_remaining, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 and R2 from the vector table
    for (int i = 0; i < NVEC; i++) begin
      run(VECS[i].pc, VECS[i].bytes, VECS[i].flow);
      chk(VECS[i].flow ? "R2 flow pc" : "R7 advance", next_pc, VECS[i].exp);
      tick();
    end
    chk("R7 no state change", stk_empty, 1);

    // R10: load with a step in the same cycle, load wins
    run(16'h0100, 3'd2, 1'b0);
    rep_load = 1'b1; rep_count = 16'd3;
    chk("R10 old count rules this cycle", next_pc, 16'h0101);
    tick();
    chk("R10 loaded value", rep_remaining, 3);
    run(16'h0100, 3'd2, 1'b0);
    chk("R3 hold pc", next_pc, 16'h0100);
    tick();
    chk("R3 decrement", rep_remaining, 2);
    run(16'h0100, 3'd2, 1'b0);
    chk("R3 hold pc again", next_pc, 16'h0100);
    tick();
    chk("R3 decrement again", rep_remaining, 1);
    run(16'h0100, 3'd2, 1'b0);
    chk("R4 last pass advances", next_pc, 16'h0101);
    tick();
    chk("R4 counter zero", rep_remaining, 0);

    // R2: flow-control step leaves repeat counter untouched
    rep_load = 1'b1; rep_count = 16'd2;
    tick();
    run(16'h0200, 3'd4, 1'b1);
    chk("R2 flow pc", next_pc, 16'h0200);
    tick();
    chk("R2 repeat kept", rep_remaining, 2);
    run(16'h0200, 3'd2, 1'b0); tick();
    run(16'h0200, 3'd2, 1'b0); tick();
    chk("R3 drained", rep_remaining, 0);

    // R5/R6: single loop frame, count 2
    push(16'h0010, 16'h0012, 16'd2);
    tick();
    chk("R8 not empty after push", stk_empty, 0);
    run(16'h0012, 3'd2, 1'b0);
    chk("R5 jump to start", next_pc, 16'h0010);
    tick();
    run(16'h0012, 3'd4, 1'b0);
    chk("R6 exit one word", next_pc, 16'h0013);
    tick();
    chk("R6 popped", stk_empty, 1);

    // R8/R9: fill the nest, overflow, contents kept
    for (int k = 0; k < 4; k++) begin
      push(16'h0030 + 16'(k), 16'h0040 + 16'(k), 16'd1);
      tick();
    end
    chk("R8 full at four", stk_full, 1);
    chk("R9 no err yet", stk_err, 0);
    push(16'h0090, 16'h0099, 16'd5);
    tick();
    chk("R9 err set", stk_err, 1);
    chk("R9 still full", stk_full, 1);
    run(16'h0099, 3'd2, 1'b0);
    chk("R9 rejected frame absent", next_pc, 16'h0099 + 16'd1);
    tick();
    chk("R9 depth kept", stk_full, 1);
    for (int k = 3; k >= 0; k--) begin
      run(16'h0040 + 16'(k), 3'd2, 1'b0);
      chk("R9 frames intact, exit", next_pc, 16'h0041 + 16'(k));
      tick();
    end
    chk("R8 empty again", stk_empty, 1);
    chk("R9 err sticky", stk_err, 1);

    // R11: pop and push in the same cycle
    push(16'h0020, 16'h0030, 16'd1);
    tick();
    run(16'h0030, 3'd2, 1'b0);
    push(16'h0050, 16'h0060, 16'd3);
    chk("R11 exit pc", next_pc, 16'h0031);
    tick();
    chk("R11 one frame left", stk_empty, 0);
    run(16'h0060, 3'd2, 1'b0);
    chk("R11 new frame on top", next_pc, 16'h0050);
    tick();
    run(16'h0060, 3'd2, 1'b0);
    chk("R5 second pass", next_pc, 16'h0050);
    tick();
    run(16'h0060, 3'd2, 1'b0);
    chk("R6 final exit", next_pc, 16'h0061);
    tick();
    chk("R11 single frame only", stk_empty, 1);

    // R1: reset clears the sticky flag
    rst_n = 1'b0;
    tick();
    chk("R1 err cleared", stk_err, 0);
    rst_n = 1'b1;

    finish_run();
  end

endmodule